// File: doc/BRIEF.md
# Memory Bitfield Operation Unit

This unit performs one bitfield operation on a big-endian, byte-addressed memory. A field is named by a base byte address, a signed bit offset counted from the most significant bit of the base byte, and a 5-bit length code. On a start pulse the unit latches the request and works out which bytes hold the field. It fetches those bytes one at a time over a byte-wide request/acknowledge port into a window of up to five bytes. It then produces the operation's result. For the modifying operations it also writes the changed window back.

Seven operations are supported: signed extract, unsigned extract, insert, change (invert), clear, set, and find-first-one. Every operation also yields N and Z flags for a condition-code stage. For every operation except insert, the flags describe the field contents as they were before any change. For insert they describe the inserted value. The memory port carries one byte per acknowledged beat. Each request holds its address, direction and write data steady until the acknowledge arrives.

Top module: `bitfield_mem_unit`

## Requirements
- R1: The effective field length is the length code when it is 1..31, and 32 when the code is 0.
- R2: Bits are numbered upward from the MSB of the base byte, and a negative offset reaches into lower addresses. The first byte touched is base + floor(offset/8), and the field starts (offset mod 8) bits, normalised to 0..7, below that byte's MSB.
- R3: The number of bytes read is ((offset mod 8) + length - 1)/8 + 1, which is 1 to 5. Exactly those bytes are read, once each, in ascending address order.
- R4: The operation code is 0 signed extract, 1 unsigned extract, 2 insert, 3 change, 4 clear, 5 set, 6 find-first-one; code 7 behaves as unsigned extract. Extracts return the field right-justified, sign-extended (0) or zero-extended (1, 7) to 32 bits.
- R5: Insert replaces the field with the low length bits of the input value and leaves every other memory bit unchanged. Its result is that value left-justified in 32 bits.
- R6: Change, clear and set invert, zero or fill the field in memory and leave all other bits unchanged. Each returns the original field left-justified in 32 bits, with low bits zero.
- R7: Find-first-one returns the signed offset plus the number of leading zeros in the field, or offset plus length when the field is all zero, modulo 2^32.
- R8: N is bit 31 and Z is the all-zero test of a flag word. The flag word is the left-justified inserted value for insert and the left-justified original field for every other operation.
- R9: Only operations 2..5 write memory. They write the same bytes that were read, in ascending order, after all reads; other operations leave memory untouched.
- R10: While mem_req is high and mem_ack low, mem_addr, mem_we and mem_wdata hold steady. Each acknowledged beat moves exactly one byte.
- R11: After reset the unit is idle with busy, done and mem_req low. busy rises the cycle after an accepted start and falls when done pulses for one cycle, and a start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| op | input | 3 | Operation code |
| base_addr | input | AW | Base byte address |
| bit_ofs | input | OFS_W | Signed bit offset |
| len_code | input | 5 | Field length code, 0 means 32 |
| ins_val | input | 32 | Value for insert |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Operation result, held until the next completion |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW | Beat byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ack on a read |
| mem_ack | input | 1 | Beat acknowledge |

## Verification
The sweep crosses every operation code with every length code and with offsets from -21 to +34. This covers negative offsets that pull the first byte below the base. A wrong floor rounding of a negative offset would touch the wrong first byte or shift every extracted bit. Five-byte windows with offsets of 7 mod 8 and full-length fields are included; a byte count capped at four or a length code 0 read as zero would drop or invent bits. The bench compares a band of memory around the base after each operation. An insert or clear mask off by one would corrupt the neighbouring bits. A flag taken after modification would flip N/Z on change and set. Find-first-one is exercised on all-zero fields and with negative offsets, where a missing length term or unsigned offset would return a wrong position.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  localparam int FW        = 32;
  localparam int LEN_W     = $clog2(FW);
  localparam int WIN_BYTES = FW / 8 + 1;
  localparam int WIN_W     = 8 * WIN_BYTES;
  localparam int CNT_W     = $clog2(WIN_BYTES + 1);

  typedef enum logic [2:0] {
    OP_SEXT = 3'd0,
    OP_UEXT = 3'd1,
    OP_INS  = 3'd2,
    OP_CHG  = 3'd3,
    OP_CLR  = 3'd4,
    OP_SET  = 3'd5,
    OP_FFO  = 3'd6,
    OP_RSV  = 3'd7
  } bf_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_FIN
  } bf_state_e;

  // length code 0 stands for a full-width field
  function automatic logic [LEN_W:0] eff_len(input logic [LEN_W-1:0] code);
    return (code == '0) ? (LEN_W+1)'(FW) : {1'b0, code};
  endfunction

  // ones in the top l bits of a field word
  function automatic logic [FW-1:0] top_mask(input logic [LEN_W:0] l);
    return ~({FW{1'b1}} >> l);
  endfunction

  function automatic logic [LEN_W:0] lead_zeros(input logic [FW-1:0] v);
    logic [LEN_W:0] n;
    logic           hit;
    n   = '0;
    hit = 1'b0;
    for (int i = FW - 1; i >= 0; i--) begin
      if (v[i]) hit = 1'b1;
      else if (!hit) n = n + 1'b1;
    end
    return n;
  endfunction

  function automatic logic [CNT_W-1:0] span_bytes(input logic [2:0] bofs,
                                                  input logic [LEN_W:0] l);
    logic [LEN_W+1:0] last_bit;
    last_bit = {{(LEN_W-1){1'b0}}, bofs} + {1'b0, l} - 1'b1;
    return CNT_W'(last_bit >> 3) + 1'b1;
  endfunction

  function automatic logic is_modify(input bf_op_e o);
    return (o == OP_INS) || (o == OP_CHG) || (o == OP_CLR) || (o == OP_SET);
  endfunction
endpackage

// File: rtl/bf_addr_calc.sv
module bf_addr_calc
  import bfm_pkg::*;
#(
  parameter int AW    = 16,
  parameter int OFS_W = 32
) (
  input  logic [AW-1:0]    base_addr,
  input  logic [OFS_W-1:0] bit_ofs,
  input  logic [LEN_W-1:0] len_code,
  output logic [AW-1:0]    first_addr,
  output logic [2:0]       bit_in_byte,
  output logic [LEN_W:0]   field_len,
  output logic [CNT_W-1:0] byte_cnt
);
  logic signed [OFS_W-1:0] byte_step;

  // arithmetic shift gives floor division for negative offsets
  assign byte_step   = $signed(bit_ofs) >>> 3;
  assign first_addr  = base_addr + AW'(byte_step);
  assign bit_in_byte = bit_ofs[2:0];
  assign field_len   = eff_len(len_code);
  assign byte_cnt    = span_bytes(bit_in_byte, field_len);
endmodule

// File: rtl/bf_field_ops.sv
module bf_field_ops
  import bfm_pkg::*;
#(
  parameter int OFS_W = 32
) (
  input  bf_op_e           op,
  input  logic [WIN_W-1:0] win,
  input  logic [2:0]       bit_in_byte,
  input  logic [LEN_W:0]   field_len,
  input  logic [OFS_W-1:0] bit_ofs,
  input  logic [FW-1:0]    ins_val,
  output logic [WIN_W-1:0] new_win,
  output logic [FW-1:0]    field_lj,
  output logic [FW-1:0]    result,
  output logic [FW-1:0]    flag_word
);
  logic [WIN_W-1:0] win_aligned;
  logic [WIN_W-1:0] win_mask;
  logic [WIN_W-1:0] ins_bits;
  logic [FW-1:0]    lmask;
  logic [FW-1:0]    ins_lj;
  logic [LEN_W:0]   right_sh;
  logic [LEN_W:0]   ffo_cnt;

  assign lmask       = top_mask(field_len);
  assign right_sh    = (LEN_W+1)'(FW) - field_len;
  assign win_aligned = win << bit_in_byte;
  assign field_lj    = win_aligned[WIN_W-1 -: FW] & lmask;
  assign ins_lj      = ins_val << right_sh;
  assign win_mask    = {lmask, {(WIN_W-FW){1'b0}}} >> bit_in_byte;
  assign ins_bits    = {ins_lj, {(WIN_W-FW){1'b0}}} >> bit_in_byte;
  assign ffo_cnt     = (field_lj == '0) ? field_len : lead_zeros(field_lj);
  assign flag_word   = (op == OP_INS) ? ins_lj : field_lj;

  always_comb begin
    unique case (op)
      OP_INS:  new_win = (win & ~win_mask) | ins_bits;
      OP_CHG:  new_win = win ^ win_mask;
      OP_CLR:  new_win = win & ~win_mask;
      OP_SET:  new_win = win | win_mask;
      default: new_win = win;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_SEXT: result = FW'($signed(field_lj) >>> right_sh);
      OP_INS:  result = ins_lj;
      OP_CHG, OP_CLR, OP_SET: result = field_lj;
      OP_FFO:  result = FW'(bit_ofs + OFS_W'(ffo_cnt));
      default: result = field_lj >> right_sh;
    endcase
  end
endmodule

// File: rtl/bf_mem_seq.sv
module bf_mem_seq
  import bfm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             modify,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             mem_ack,
  input  logic [7:0]       mem_rdata,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [CNT_W-1:0] byte_idx,
  output logic [WIN_W-1:0] win_q,
  output logic             rd_beat,
  output logic             wr_beat,
  output logic             fin
);
  bf_state_e state;
  logic      last_beat;

  assign busy      = (state != ST_IDLE);
  assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign rd_beat   = (state == ST_READ) && mem_ack;
  assign wr_beat   = (state == ST_WRITE) && mem_ack;
  assign fin       = (state == ST_FIN);
  assign last_beat = (byte_idx == byte_cnt - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      byte_idx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_READ;
          byte_idx <= '0;
        end
        ST_READ: if (mem_ack) begin
          if (last_beat) begin
            byte_idx <= '0;
            state    <= modify ? ST_WRITE : ST_FIN;
          end else begin
            byte_idx <= byte_idx + 1'b1;
          end
        end
        ST_WRITE: if (mem_ack) begin
          if (last_beat) state <= ST_FIN;
          else byte_idx <= byte_idx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // one capture register per window byte lane
  for (genvar g = 0; g < WIN_BYTES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q[WIN_W-1-8*g -: 8] <= '0;
      else if (accept && !busy) win_q[WIN_W-1-8*g -: 8] <= '0;
      else if (rd_beat && byte_idx == CNT_W'(g)) win_q[WIN_W-1-8*g -: 8] <= mem_rdata;
    end
  end
endmodule

// File: rtl/bitfield_mem_unit.sv
module bitfield_mem_unit
  import bfm_pkg::*;
#(
  parameter int AW    = 16,
  parameter int OFS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic [AW-1:0]    base_addr,
  input  logic [OFS_W-1:0] bit_ofs,
  input  logic [4:0]       len_code,
  input  logic [31:0]      ins_val,
  output logic             busy,
  output logic             done,
  output logic [31:0]      result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  input  logic             mem_ack
);
  bf_op_e           op_q;
  logic [AW-1:0]    base_q;
  logic [OFS_W-1:0] ofs_q;
  logic [LEN_W-1:0] len_q;
  logic [FW-1:0]    ins_q;
  logic             accept;
  logic             modify_q;
  logic [AW-1:0]    first_addr;
  logic [2:0]       bit_in_byte;
  logic [LEN_W:0]   field_len;
  logic [CNT_W-1:0] byte_cnt;
  logic [CNT_W-1:0] byte_idx;
  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] new_win;
  logic [FW-1:0]    field_lj;
  logic [FW-1:0]    op_result;
  logic [FW-1:0]    flag_word;
  logic             rd_beat;
  logic             wr_beat;
  logic             fin;
  logic [7:0]       wr_lane [WIN_BYTES];

  assign accept   = start && !busy;
  assign modify_q = is_modify(op_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_SEXT;
      base_q <= '0;
      ofs_q  <= '0;
      len_q  <= '0;
      ins_q  <= '0;
    end else if (accept) begin
      op_q   <= bf_op_e'(op);
      base_q <= base_addr;
      ofs_q  <= bit_ofs;
      len_q  <= len_code;
      ins_q  <= ins_val;
    end
  end

  bf_addr_calc #(.AW(AW), .OFS_W(OFS_W)) u_addr (
    .base_addr  (base_q),
    .bit_ofs    (ofs_q),
    .len_code   (len_q),
    .first_addr (first_addr),
    .bit_in_byte(bit_in_byte),
    .field_len  (field_len),
    .byte_cnt   (byte_cnt)
  );

  bf_mem_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .modify   (modify_q),
    .byte_cnt (byte_cnt),
    .mem_ack  (mem_ack),
    .mem_rdata(mem_rdata),
    .busy     (busy),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .byte_idx (byte_idx),
    .win_q    (win_q),
    .rd_beat  (rd_beat),
    .wr_beat  (wr_beat),
    .fin      (fin)
  );

  bf_field_ops #(.OFS_W(OFS_W)) u_ops (
    .op         (op_q),
    .win        (win_q),
    .bit_in_byte(bit_in_byte),
    .field_len  (field_len),
    .bit_ofs    (ofs_q),
    .ins_val    (ins_q),
    .new_win    (new_win),
    .field_lj   (field_lj),
    .result     (op_result),
    .flag_word  (flag_word)
  );

  for (genvar g = 0; g < WIN_BYTES; g++) begin : g_wlane
    assign wr_lane[g] = new_win[WIN_W-1-8*g -: 8];
  end

  assign mem_addr  = first_addr + AW'(byte_idx);
  assign mem_wdata = wr_lane[byte_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      done <= fin;
      if (fin) begin
        result <= op_result;
        flag_n <= flag_word[FW-1];
        flag_z <= (flag_word == '0);
      end
    end
  end
endmodule

// File: rtl/bfm_checker.sv
module bfm_checker
  import bfm_pkg::*;
#(
  parameter int AW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [AW-1:0]    mem_addr,
  input logic [7:0]       mem_wdata,
  input logic             modify_q,
  input logic [CNT_W-1:0] byte_cnt,
  input logic             rd_beat,
  input logic             wr_beat,
  input logic [2:0]       op_q,
  input logic [31:0]      result,
  input logic             flag_z
);
  logic [CNT_W:0] rd_seen;
  logic [CNT_W:0] wr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_seen <= '0;
      wr_seen <= '0;
    end else if (!busy) begin
      rd_seen <= '0;
      wr_seen <= '0;
    end else begin
      if (rd_beat) rd_seen <= rd_seen + 1'b1;
      if (wr_beat) wr_seen <= wr_seen + 1'b1;
    end
  end

  assert_hold_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_req_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_write_only_modify_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> modify_q);

  assert_writes_after_reads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beat |-> (rd_seen == {1'b0, byte_cnt}));

  assert_span_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (byte_cnt >= 1 && byte_cnt <= CNT_W'(WIN_BYTES)));

  assert_read_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat |-> (rd_seen < {1'b0, byte_cnt}));

  assert_write_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beat |-> (wr_seen < {1'b0, byte_cnt}));

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && (op_q == 3'd1) |-> (flag_z == (result == 32'd0)));
endmodule

bind bitfield_mem_unit bfm_checker #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .modify_q (modify_q),
  .byte_cnt (byte_cnt),
  .rd_beat  (rd_beat),
  .wr_beat  (wr_beat),
  .op_q     (op_q),
  .result   (result),
  .flag_z   (flag_z)
);

// File: tb/bitfield_mem_unit_test.sv
module bitfield_mem_unit_test;
  localparam int AW   = 16;
  localparam int BASE = 100;
  localparam int LO   = 80;
  localparam int HI   = 127;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [AW-1:0] base_addr = '0;
  logic [31:0] bit_ofs = '0;
  logic [4:0]  len_code = '0;
  logic [31:0] ins_val = '0;
  logic        busy, done, flag_n, flag_z, mem_req, mem_we;
  logic [31:0] result;
  logic [AW-1:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;

  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rd_n, wr_n, rd_first, rd_prev, wr_prev, rd_order_bad, wr_order_bad;

  always #10 clk = ~clk;

  bitfield_mem_unit #(.AW(AW), .OFS_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base_addr(base_addr),
    .bit_ofs(bit_ofs), .len_code(len_code), .ins_val(ins_val), .busy(busy),
    .done(done), .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // byte-wide memory responder: one acknowledged beat every two cycles
  initial forever begin
    @(negedge clk);
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        if (wr_n > 0 && int'(mem_addr) != wr_prev + 1) wr_order_bad++;
        wr_prev = int'(mem_addr);
        wr_n++;
        mem[mem_addr[7:0]] = mem_wdata;
      end else begin
        if (rd_n == 0) rd_first = int'(mem_addr);
        else if (int'(mem_addr) != rd_prev + 1) rd_order_bad++;
        if (wr_n > 0) rd_order_bad++;
        rd_prev = int'(mem_addr);
        rd_n++;
        mem_rdata = mem[mem_addr[7:0]];
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  initial forever begin
    @(posedge clk);
    cyc++;
    if (cyc > 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int floor8(input int p);
    return (p >= 0) ? p / 8 : -((-p + 7) / 8);
  endfunction

  function automatic int bit_at(input int p);
    int fl = floor8(p);
    return (shadow[BASE + fl] >> (7 - (p - 8 * fl))) & 1;
  endfunction

  task automatic set_bit(input int p, input int v);
    int fl = floor8(p);
    int b = 7 - (p - 8 * fl);
    if (v != 0) shadow[BASE + fl] = shadow[BASE + fl] | 8'(1 << b);
    else shadow[BASE + fl] = shadow[BASE + fl] & ~8'(1 << b);
  endtask

  task automatic run_op(input int o, input int ofs, input int code, input logic [31:0] v,
                        input bit poke);
    int len, nexp, ffo_i;
    logic [31:0] f, lj, vlj, flagw, exp_res;
    bit got;
    len = (code == 0) ? 32 : code;
    f = '0;
    ffo_i = -1;
    for (int i = 0; i < len; i++) begin
      f = {f[30:0], 1'(bit_at(ofs + i))};
      if (ffo_i < 0 && bit_at(ofs + i) == 1) ffo_i = i;
    end
    lj  = f << (32 - len);
    vlj = v << (32 - len);
    case (o)
      0: exp_res = (len < 32 && f[len-1]) ? (f | (32'hFFFF_FFFF << len)) : f;
      2: exp_res = vlj;
      3, 4, 5: exp_res = lj;
      6: exp_res = 32'(ofs + ((ffo_i < 0) ? len : ffo_i));
      default: exp_res = f;
    endcase
    flagw = (o == 2) ? vlj : lj;
    nexp = floor8(ofs + len - 1) - floor8(ofs) + 1;
    for (int i = 0; i < len; i++) begin
      case (o)
        2: set_bit(ofs + i, int'(v[len - 1 - i]));
        3: set_bit(ofs + i, 1 - bit_at(ofs + i));
        4: set_bit(ofs + i, 0);
        5: set_bit(ofs + i, 1);
        default: ;
      endcase
    end
    rd_n = 0; wr_n = 0; rd_order_bad = 0; wr_order_bad = 0;
    @(negedge clk);
    op = 3'(o); bit_ofs = 32'(ofs); len_code = 5'(code); ins_val = v;
    base_addr = AW'(BASE); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      op = 3'd5; len_code = 5'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    got = 1'b0;
    for (int t = 0; t < 100; t++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
    chk("R11", "done seen", longint'(got), 1);
    chk("R4 R5 R6 R7", $sformatf("result op=%0d ofs=%0d len=%0d", o, ofs, code), result, exp_res);
    chk("R8", "flag_n", flag_n, flagw[31]);
    chk("R8", "flag_z", flag_z, longint'(flagw == 0));
    chk("R3", "bytes read", rd_n, nexp);
    chk("R2", "first byte", rd_first, BASE + floor8(ofs));
    chk("R3", "read order", rd_order_bad, 0);
    chk("R9", "bytes written", wr_n, (o >= 2 && o <= 5) ? nexp : 0);
    chk("R9", "write order", wr_order_bad, 0);
    for (int a = LO; a <= HI; a++)
      if (mem[a] != shadow[a]) chk("R5 R6 R9", $sformatf("mem[%0d]", a), mem[a], shadow[a]);
    total++;
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin
      mem[a] = 8'((a * 37 + 11) ^ (a >> 2));
      shadow[a] = mem[a];
    end
    repeat (3) @(negedge clk);
    chk("R11", "reset busy", busy, 0);
    chk("R11", "reset done", done, 0);
    chk("R11", "reset mem_req", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: code 0 is a 32-bit field; R7: all-zero field at negative offset
    for (int a = 96; a < 104; a++) begin mem[a] = 8'h00; shadow[a] = 8'h00; end
    run_op(6, -13, 0, 32'h0, 1'b0);
    run_op(1, 7, 0, 32'h0, 1'b0);
    // R11: a start while busy is ignored
    run_op(2, 5, 9, 32'h0000_01A5, 1'b1);
    run_op(0, -3, 12, 32'h0, 1'b1);
    // sweep over all operation codes, length codes and a range of offsets
    for (int o = 0; o < 8; o++)
      for (int code = 0; code < 32; code++)
        for (int k = 0; k < 12; k++)
          run_op(o, -21 + k * 5, code, 32'h9E37_79B9 * 32'(o * 41 + code * 7 + k + 1), 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule